// File: doc/BRIEF.md
# Mapped Interrupt Dispatch Controller

This block collects 64 level-sensitive interrupt lines and presents at most one of them at a time as a pending request toward the CPU side. Lines 0 to 31 come from PCI slots. Each group of four consecutive PCI lines shares one mapping register. Lines 32 to 63 come from on-board devices, and each of these lines has a mapping register of its own. Every mapping register holds an enable flag in bit 31. Its lower 31 bits hold a fixed identification pattern that software can read but never change.

Software drives the block through a small memory-mapped register port. Through it, software sets and clears the enable flags and acknowledges the current request, either by PCI group or by exact on-board line. A request stays presented until software acknowledges it or withdraws it. The one exception is a newly rising enabled PCI line, which takes over the request at once. When no request is outstanding, the block picks the lowest-numbered line that is both active and enabled.

Top module: `irq_disp_top`

## Requirements
- R1: Line n < 32 is governed by PCI map register n/4. Line n >= 32 is governed by on-board map register n-32. A line can become the request only while bit 31 (enable) of its map register is set.
- R2: A map register write changes only bit 31. A read returns {enable, low pattern}. For PCI map g the low pattern is 0x7C0 | (4*g). For on-board map k it is 0x7E0 | k. Reset clears every enable, so a map reads as its low pattern alone.
- R3: Register offsets are as follows. PCI map g sits at 0xC04+8g. On-board map k sits at 0x1004+8k. The PCI group-g acknowledge sits at 0x1404+32g. The on-board line-k acknowledge sits at 0x1804+8k. An access with address bit 2 clear has no effect. A read with bit 2 clear, or outside the map windows, returns 0.
- R4: At most one request is presented at a time, as req_valid plus a 6-bit line number in req_line. Both outputs are registered and change on the clock edge that samples the cause. req_line is 0 while req_valid is low.
- R5: An outstanding request stays presented unchanged, even after its line falls, until it is acknowledged, withdrawn or pre-empted.
- R6: A PCI line that rises while enabled becomes the request on the next edge, even if another request is outstanding. If several such lines rise in the same cycle, the lowest-numbered one wins.
- R7: An on-board line becomes the request only when no request is outstanding. It never pre-empts.
- R8: While no request is outstanding, the lowest-numbered line that is both active and enabled is chosen. All PCI lines are therefore ahead of all on-board lines.
- R9: A PCI acknowledge for group g clears the request only if the request is a PCI line in group g. An on-board acknowledge for line k clears the request only if the request is exactly line 32+k. Any other acknowledge has no effect.
- R10: Writing 0 to bit 31 of the map that governs the outstanding request withdraws that request. Disabling any other map leaves the request unchanged.
- R11: When a register write and input levels arrive in the same cycle, the write takes effect first. A single selection then runs over the updated state, so an acknowledge can hand over directly to another active line on the same edge.
- R12: Reset (rst_n low, asynchronous) drops the request at once and clears all enables. Lines that stay high after reset release produce no request until software enables them again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 64 | Interrupt line levels; bits 0-31 are PCI lines, bits 32-63 are on-board lines |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | output | 1 | A request is outstanding |
| req_line | output | 6 | Line number of the outstanding request |

## Verification
A corrupted enable flag is visible in two ways: through the map read-back in the same cycle, and as a request that appears, or fails to appear, one edge after the line is active. A wrong group or line match in the acknowledge decode shows one edge after the write, either as a request that is not cleared or as one cleared by the wrong acknowledge. Errors in the pre-emption and selection order show on the first edge where two candidate lines compete. The stimulus therefore sets up those conflicts on purpose: simultaneous rises, an on-board line rising over an outstanding request, and an acknowledge that lands while other lines are still high.

// File: rtl/irq_disp_pkg.sv
`timescale 1ns/1ps
package irq_disp_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  // Register window bases (byte offsets)
  localparam logic [ADDR_W-1:0] PMAP_BASE = 16'h0C00;
  localparam logic [ADDR_W-1:0] OMAP_BASE = 16'h1000;
  localparam logic [ADDR_W-1:0] PCLR_BASE = 16'h1400;
  localparam logic [ADDR_W-1:0] OCLR_BASE = 16'h1800;

  // Fixed identification pattern held in the low bits of every map register
  localparam logic [DATA_W-1:0] MAP_TAG    = 32'h0000_07C0;
  localparam logic [DATA_W-1:0] OB_TAG_BIT = 32'h0000_0020;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_PMAP,
    WIN_OMAP,
    WIN_PCLR,
    WIN_OCLR
  } win_e;

  function automatic logic [DATA_W-2:0] pmap_low(input int unsigned grp_idx,
                                                 input int unsigned grp_size);
    logic [DATA_W-1:0] v;
    v = MAP_TAG | DATA_W'(grp_idx * grp_size);
    return v[DATA_W-2:0];
  endfunction

  function automatic logic [DATA_W-2:0] omap_low(input int unsigned ob_idx);
    logic [DATA_W-1:0] v;
    v = MAP_TAG | OB_TAG_BIT | DATA_W'(ob_idx);
    return v[DATA_W-2:0];
  endfunction

endpackage

// File: rtl/irq_disp_lowest.sv
`timescale 1ns/1ps
// Lowest-index-first priority encoder.
module irq_disp_lowest #(
  parameter  int unsigned W  = 64,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_disp_regs.sv
`timescale 1ns/1ps
// Register port decode, enable storage and read-back.
module irq_disp_regs
  import irq_disp_pkg::*;
#(
  parameter  int unsigned N_GRP    = 8,
  parameter  int unsigned GRP_SIZE = 4,
  parameter  int unsigned N_OB     = 32,
  localparam int unsigned N_PCI    = N_GRP * GRP_SIZE,
  localparam int unsigned N_LINES  = N_PCI + N_OB,
  localparam int unsigned GIW      = $clog2(N_GRP),
  localparam int unsigned OIW      = $clog2(N_OB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output win_e               win,
  output logic               wr_act,
  output logic [GIW-1:0]     gidx,
  output logic [OIW-1:0]     oidx,
  output logic               en_bit,
  output logic [N_LINES-1:0] line_en_nxt
);

  // Low address bit of each window's upper compare
  localparam int unsigned MAP_STRIDE_LG = 3;                            // 8 bytes per map
  localparam int unsigned CLR_STRIDE_LG = $clog2(GRP_SIZE) + MAP_STRIDE_LG;
  localparam int unsigned PM_LO = GIW + MAP_STRIDE_LG;
  localparam int unsigned OM_LO = OIW + MAP_STRIDE_LG;
  localparam int unsigned PC_LO = GIW + CLR_STRIDE_LG;

  logic [N_GRP-1:0] pci_en_q, pci_en_d;
  logic [N_OB-1:0]  ob_en_q,  ob_en_d;
  logic             pci_en_upd, ob_en_upd;
  logic             unused_bits;

  assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-2:0]};
  assign en_bit      = reg_wdata[DATA_W-1];
  assign wr_act      = reg_wr & reg_addr[2];

  // Window decode
  always_comb begin
    win = WIN_NONE;
    if (reg_addr[ADDR_W-1:PM_LO] == PMAP_BASE[ADDR_W-1:PM_LO])      win = WIN_PMAP;
    else if (reg_addr[ADDR_W-1:OM_LO] == OMAP_BASE[ADDR_W-1:OM_LO]) win = WIN_OMAP;
    else if (reg_addr[ADDR_W-1:PC_LO] == PCLR_BASE[ADDR_W-1:PC_LO]) win = WIN_PCLR;
    else if (reg_addr[ADDR_W-1:OM_LO] == OCLR_BASE[ADDR_W-1:OM_LO]) win = WIN_OCLR;
  end

  assign gidx = (win == WIN_PCLR) ? reg_addr[PC_LO-1:CLR_STRIDE_LG]
                                  : reg_addr[PM_LO-1:MAP_STRIDE_LG];
  assign oidx = reg_addr[OM_LO-1:MAP_STRIDE_LG];

  // Enable next state (write applied before selection)
  assign pci_en_upd = wr_act && (win == WIN_PMAP);
  assign ob_en_upd  = wr_act && (win == WIN_OMAP);

  always_comb begin
    pci_en_d = pci_en_q;
    ob_en_d  = ob_en_q;
    if (pci_en_upd) pci_en_d[gidx] = en_bit;
    if (ob_en_upd)  ob_en_d[oidx]  = en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_en_q <= '0;
      ob_en_q  <= '0;
    end else begin
      if (pci_en_upd) pci_en_q <= pci_en_d;
      if (ob_en_upd)  ob_en_q  <= ob_en_d;
    end
  end

  // Per-line enable view, including this cycle's write
  for (genvar n = 0; n < int'(N_PCI); n++) begin : g_pci_line
    assign line_en_nxt[n] = pci_en_d[n / GRP_SIZE];
  end
  for (genvar k = 0; k < int'(N_OB); k++) begin : g_ob_line
    assign line_en_nxt[N_PCI + k] = ob_en_d[k];
  end

  // Read-back
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[2]) begin
      case (win)
        WIN_PMAP: reg_rdata = {pci_en_q[gidx], pmap_low(int'(gidx), GRP_SIZE)};
        WIN_OMAP: reg_rdata = {ob_en_q[oidx], omap_low(int'(oidx))};
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_disp_req.sv
`timescale 1ns/1ps
// Single outstanding request tracking, acknowledge matching and selection.
module irq_disp_req
  import irq_disp_pkg::*;
#(
  parameter  int unsigned N_GRP    = 8,
  parameter  int unsigned GRP_SIZE = 4,
  parameter  int unsigned N_OB     = 32,
  localparam int unsigned N_PCI    = N_GRP * GRP_SIZE,
  localparam int unsigned N_LINES  = N_PCI + N_OB,
  localparam int unsigned LW       = $clog2(N_LINES),
  localparam int unsigned PW       = $clog2(N_PCI),
  localparam int unsigned GIW      = $clog2(N_GRP),
  localparam int unsigned OIW      = $clog2(N_OB),
  localparam int unsigned GS       = $clog2(GRP_SIZE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lvl,
  input  logic [N_LINES-1:0] line_en_nxt,
  input  win_e               win,
  input  logic               wr_act,
  input  logic [GIW-1:0]     gidx,
  input  logic [OIW-1:0]     oidx,
  input  logic               en_bit,
  output logic               req_valid,
  output logic [LW-1:0]      req_line
);

  logic [N_PCI-1:0] pend_q;
  logic             req_v_q, req_v_d, req_v_mid;
  logic [LW-1:0]    req_q, req_d;
  logic             req_upd;

  logic [N_PCI-1:0] pci_rise;
  logic             rise_hit;
  logic [PW-1:0]    rise_idx;
  logic             scan_hit;
  logic [LW-1:0]    scan_idx;
  logic             grp_match, ob_match;

  // Candidate vectors
  assign pci_rise = irq_lvl[N_PCI-1:0] & ~pend_q & line_en_nxt[N_PCI-1:0];

  irq_disp_lowest #(.W(N_PCI)) u_rise_pick (
    .vec (pci_rise),
    .hit (rise_hit),
    .idx (rise_idx)
  );

  irq_disp_lowest #(.W(N_LINES)) u_scan_pick (
    .vec (irq_lvl & line_en_nxt),
    .hit (scan_hit),
    .idx (scan_idx)
  );

  // Does the outstanding request belong to the addressed map or acknowledge?
  assign grp_match = req_v_q && !req_q[LW-1] && (req_q[LW-2:GS] == gidx);
  assign ob_match  = req_v_q && (req_q == {1'b1, oidx});

  // Next state: write effects first, then one selection
  always_comb begin
    req_v_mid = req_v_q;
    if (wr_act) begin
      case (win)
        WIN_PMAP: if (!en_bit && grp_match) req_v_mid = 1'b0;
        WIN_OMAP: if (!en_bit && ob_match)  req_v_mid = 1'b0;
        WIN_PCLR: if (grp_match)            req_v_mid = 1'b0;
        WIN_OCLR: if (ob_match)             req_v_mid = 1'b0;
        default:  req_v_mid = req_v_q;
      endcase
    end

    req_v_d = req_v_mid;
    req_d   = req_q;
    if (rise_hit) begin
      req_v_d = 1'b1;
      req_d   = LW'(rise_idx);
    end else if (!req_v_mid) begin
      req_v_d = scan_hit;
      req_d   = scan_hit ? scan_idx : '0;
    end
  end

  assign req_upd = (req_v_d != req_v_q) || (req_d != req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      req_v_q <= 1'b0;
      req_q   <= '0;
    end else begin
      pend_q <= irq_lvl[N_PCI-1:0];
      if (req_upd) begin
        req_v_q <= req_v_d;
        req_q   <= req_d;
      end
    end
  end

  assign req_valid = req_v_q;
  assign req_line  = req_q;

endmodule

// File: rtl/irq_disp_top.sv
`timescale 1ns/1ps
module irq_disp_top
  import irq_disp_pkg::*;
#(
  parameter  int unsigned N_GRP    = 8,
  parameter  int unsigned GRP_SIZE = 4,
  parameter  int unsigned N_OB     = 32,
  localparam int unsigned N_LINES  = N_GRP * GRP_SIZE + N_OB,
  localparam int unsigned LW       = $clog2(N_LINES),
  localparam int unsigned GIW      = $clog2(N_GRP),
  localparam int unsigned OIW      = $clog2(N_OB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lvl,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               req_valid,
  output logic [LW-1:0]      req_line
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  win_e               win;
  logic               wr_act;
  logic [GIW-1:0]     gidx;
  logic [OIW-1:0]     oidx;
  logic               en_bit;
  logic [N_LINES-1:0] line_en_nxt;

  irq_disp_regs #(
    .N_GRP    (N_GRP),
    .GRP_SIZE (GRP_SIZE),
    .N_OB     (N_OB)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .win         (win),
    .wr_act      (wr_act),
    .gidx        (gidx),
    .oidx        (oidx),
    .en_bit      (en_bit),
    .line_en_nxt (line_en_nxt)
  );

  irq_disp_req #(
    .N_GRP    (N_GRP),
    .GRP_SIZE (GRP_SIZE),
    .N_OB     (N_OB)
  ) u_req (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .irq_lvl     (irq_lvl),
    .line_en_nxt (line_en_nxt),
    .win         (win),
    .wr_act      (wr_act),
    .gidx        (gidx),
    .oidx        (oidx),
    .en_bit      (en_bit),
    .req_valid   (req_valid),
    .req_line    (req_line)
  );

endmodule

// File: rtl/irq_disp_chk.sv
`timescale 1ns/1ps
module irq_disp_chk #(
  parameter  int unsigned N_PCI   = 32,
  parameter  int unsigned N_LINES = 64,
  localparam int unsigned LW      = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_lvl,
  input logic               reg_wr,
  input logic [15:0]        reg_addr,
  input logic [31:0]        reg_rdata,
  input logic               req_valid,
  input logic [LW-1:0]      req_line
);

  // R5: with no write and no PCI rise, an outstanding request is held
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reg_wr &&
     ((irq_lvl[N_PCI-1:0] & ~$past(irq_lvl[N_PCI-1:0])) == '0))
    |=> (req_valid && $stable(req_line)));

  // R8: no active line while idle keeps the block idle
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && (irq_lvl == '0)) |=> !req_valid);

  // R1: a newly presented line was active in the cycle that selected it
  p_new_line_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!$past(req_valid) || (req_line != $past(req_line))))
    |-> ((($past(irq_lvl) >> req_line) & N_LINES'(1)) != '0));

  // R3: reads with address bit 2 clear return zero
  p_zero_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr[2] |-> (reg_rdata == '0));

  // R2: low bits of a PCI map read-back are the fixed pattern
  p_pmap_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr[15:6] == 10'h030) && reg_addr[2])
    |-> (reg_rdata[30:0] == (31'h7C0 | {26'd0, reg_addr[5:3], 2'b00})));

  // R4: idle request carries line number zero
  p_idle_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_line == '0));

endmodule

bind irq_disp_top irq_disp_chk #(
  .N_PCI   (N_GRP * GRP_SIZE),
  .N_LINES (N_LINES)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .irq_lvl   (irq_lvl),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .req_valid (req_valid),
  .req_line  (req_line)
);

// File: tb/test_irq_disp_top.sv
`timescale 1ns/1ps
module test_irq_disp_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_lvl;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [5:0]  req_line;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  irq_disp_top i_irq_disp_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lvl   (irq_lvl),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_line  (req_line)
  );

  // Monitor: compare request outputs against queued expectations
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [6:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({req_valid, req_line} !== e) begin
        bad++;
        $display("FAIL %s: valid/line actual=%0b/%0d expected=%0b/%0d",
                 t, req_valid, req_line, e[6], e[5:0]);
      end
    end
  end

  // Driver: one cycle of stimulus, expectation for the state after the edge
  task automatic cyc(input logic [63:0] lvl, input logic wr, input logic [15:0] a,
                     input logic [31:0] d, input logic ev, input logic [5:0] ei,
                     input string tag);
    @(negedge clk);
    irq_lvl   = lvl;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    #1;
    exp_q.push_back({ev, ei});
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_wr   = 1'b0;
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s: rdata actual=%h expected=%h", tag, reg_rdata, e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_idle_now(input string tag);
    total++;
    if (req_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: valid actual=%0b expected=0", tag, req_valid);
    end
  endtask

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [63:0] Z   = 64'd0;

  function automatic logic [63:0] L(input int n);
    return 64'd1 << n;
  endfunction

  initial begin
    rst_n = 1'b0; irq_lvl = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    #1 chk_idle_now("R12 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Power-up read-back and decode
    rd(16'h0C04, 32'h0000_07C0, "R2 pci map 0");
    rd(16'h0C1C, 32'h0000_07CC, "R2 pci map 3");
    rd(16'h102C, 32'h0000_07E5, "R2 ob map 5");
    rd(16'h10FC, 32'h0000_07FF, "R2 ob map 31");
    rd(16'h0C00, 32'h0, "R3 bit2 clear read");
    rd(16'h2004, 32'h0, "R3 outside windows");

    // Gating by enable, then enable with full-word write
    cyc(L(5), 0, 16'h0, 0, 0, 0, "R1 disabled group");
    cyc(L(5), 1, 16'h0C0C, 32'hFFFF_FFFF, 1, 5, "R8 enable picks line");
    rd(16'h0C0C, 32'h8000_07C4, "R2 only bit31 written");
    cyc(Z, 0, 16'h0, 0, 1, 5, "R5 held after line drops");
    cyc(Z, 1, 16'h1444, 0, 1, 5, "R9 wrong pci group ack");
    cyc(Z, 1, 16'h1420, 0, 1, 5, "R3 ack with bit2 clear");
    cyc(Z, 1, 16'h1424, 0, 0, 0, "R9 pci group ack");

    // On-board vs PCI pre-emption
    cyc(Z, 1, 16'h101C, EN, 0, 0, "R4 enable ob 3");
    cyc(Z, 1, 16'h0C04, EN, 0, 0, "R4 enable group 0");
    cyc(L(35), 0, 16'h0, 0, 1, 35, "R7 ob line while idle");
    cyc(L(35) | L(2), 0, 16'h0, 0, 1, 2, "R6 pci rise preempts");
    cyc(L(35), 1, 16'h1404, 0, 1, 35, "R11 ack then reselect");

    // On-board acknowledge and withdraw
    cyc(L(35), 1, 16'h1054, EN, 1, 35, "R4 enable ob 10");
    cyc(L(35) | L(42), 0, 16'h0, 0, 1, 35, "R7 ob rise no preempt");
    cyc(L(42), 1, 16'h181C, 0, 1, 42, "R9 ob exact ack");
    cyc(L(42), 1, 16'h1824, 0, 1, 42, "R9 ob wrong line ack");
    cyc(L(42), 1, 16'h101C, 0, 1, 42, "R10 other map disable");
    cyc(L(42), 1, 16'h1054, 0, 0, 0, "R10 owning map disable");

    // Ordering
    cyc(Z, 1, 16'h0C3C, EN, 0, 0, "R4 enable group 7");
    cyc(Z, 1, 16'h1004, EN, 0, 0, "R4 enable ob 0");
    cyc(L(30) | L(32), 0, 16'h0, 0, 1, 30, "R6 pci rise over ob");
    cyc(L(29) | L(30) | L(31) | L(32), 0, 16'h0, 0, 1, 29, "R6 lowest simultaneous rise");
    cyc(L(29) | L(30) | L(31) | L(32), 0, 16'h0, 0, 1, 29, "R4 single request");
    cyc(L(31) | L(32), 1, 16'h14E4, 0, 1, 31, "R8 pci before ob");
    cyc(L(32), 1, 16'h14E4, 0, 1, 32, "R8 ob when pci none");

    // Reset mid-run
    drain();
    irq_lvl = L(29) | L(32);
    rst_n = 1'b0;
    #1 chk_idle_now("R12 async drop");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(16'h0C3C, 32'h0000_07DC, "R12 group enable cleared");
    rd(16'h1004, 32'h0000_07E0, "R12 ob enable cleared");
    cyc(L(29) | L(32), 0, 16'h0, 0, 0, 0, "R12 high lines ignored");
    cyc(L(29) | L(32), 1, 16'h0C3C, EN, 1, 29, "R1 re-enable");
    cyc(L(29) | L(32), 1, 16'h0C3C, 32'h7FFF_FFFF, 0, 0, "R10 withdraw pci");
    rd(16'h0C3C, 32'h0000_07DC, "R2 low bits kept");

    drain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule